// File: doc/BRIEF.md
# Flash Sector Write-Protection Controller

This block guards the program and erase engine of a 256K x 8 parallel flash model. It watches the raw bus strobes and decides, once per write strobe, whether the write may reach the array. A strobe counts as a write only when chip enable and write enable stay low together for a set number of clock cycles. Shorter strobes are treated as noise and produce nothing.

The block decodes the target address into one of five sectors. It holds a sticky lock flag for the boot sector. A single-cycle command pulse sets the flag, and only the power-on reset clears it, because it stands for a non-volatile bit. A high-voltage override input lifts the lock, but only when it is held through the whole strobe. A supply-low sense input and the output-enable state also block writes.

In identification mode, a read of the boot sector's offset-2 location returns the lock state on data bit 0.

Top module: `flash_sector_guard`

## Requirements
- R1: Each decision reports a 3-bit sector code with grant or reject. The codes are 0 for boot, 1 for the lower parameter sector, 2 for the upper parameter sector, 3 for the 96 KB main sector and 4 for the 128 KB main sector. With TOP_BOOT=1 the ranges are as follows: boot is 3C000h-3FFFFh, the lower parameter sector is 38000h-39FFFh, the upper parameter sector is 3A000h-3BFFFh, the 96 KB main sector is 20000h-37FFFh and the 128 KB main sector is 00000h-1FFFFh.
- R2: A write is recognised when ce_n and we_n have been low together on FILT consecutive rising edges with oe_n high. Exactly one grant or reject pulse, one cycle long, follows in the cycle after the FILT-th such edge, whatever the strobe's total length.
- R3: A strobe with fewer than FILT consecutive low edges produces neither grant nor reject.
- R4: If oe_n is low on the qualifying edge, the write is inhibited and produces neither grant nor reject.
- R5: If supply_low is high on the qualifying edge, the write is rejected, whatever its sector.
- R6: After one lockout_cmd pulse, every write to the boot sector is rejected. Writes to the other sectors are still granted.
- R7: If hv_override is high on every edge of the qualifying window, a boot-sector write is granted despite the lock. If it is low on any edge of that window, the write is rejected. Once the override is released, the lock applies again.
- R8: After por_n, grant and reject are 0 and the lock is clear. Only por_n clears the lock.
- R9: id_dout carries {7'b0, lock} when id_mode is high, ce_n and oe_n are low and addr equals the status location. The status location is 3C002h when TOP_BOOT=1. In every other case id_dout is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Target byte address |
| supply_low | input | 1 | Supply below its threshold |
| hv_override | input | 1 | High-voltage lock override |
| lockout_cmd | input | 1 | One-cycle pulse that sets the boot lock |
| id_mode | input | 1 | Identification mode active |
| grant | output | 1 | One-cycle pulse: write allowed |
| reject | output | 1 | One-cycle pulse: write refused |
| sector | output | 3 | Sector code of the last decision |
| id_dout | output | 8 | Identification-mode read data |

## Verification
The bench builds the block with its defaults: TOP_BOOT=1, ADDR_W=18 and FILT=3. With FILT=3, strobes of one and two cycles fall short of the filter and strobes of three to five cycles pass it. This exposes both sides of the filter edge and the single decision per long strobe. The top-boot layout puts the lock status read at 3C002h. It also places every sector boundary inside the random address range, so the lock, the override window and supply-low can be mixed with all five sector codes.

// File: rtl/flash_sector_guard.sv
module flash_sector_guard #(
  parameter int ADDR_W   = 18,
  parameter bit TOP_BOOT = 1'b1,
  parameter int FILT     = 3
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              supply_low,
  input  logic              hv_override,
  input  logic              lockout_cmd,
  input  logic              id_mode,
  output logic              grant,
  output logic              reject,
  output logic [2:0]        sector,
  output logic [7:0]        id_dout
);
  localparam int CW = $clog2(FILT + 1);
  localparam int US = ADDR_W - 6;
  localparam logic [ADDR_W-1:0] STAT_ADDR =
    TOP_BOOT ? ADDR_W'((60 << US) | 2) : ADDR_W'(2);

  logic [5:0]    unit;
  logic [2:0]    sec;
  logic [CW-1:0] cnt;
  logic          ovr_run, locked;
  logic          low, fire, write, boot, held, refuse;

  assign unit = addr[ADDR_W-1 -: 6];

  always_comb begin
    if (TOP_BOOT) begin
      if (unit >= 6'd60)      sec = 3'd0;
      else if (unit >= 6'd58) sec = 3'd2;
      else if (unit >= 6'd56) sec = 3'd1;
      else if (unit >= 6'd32) sec = 3'd3;
      else                    sec = 3'd4;
    end else begin
      if (unit < 6'd4)        sec = 3'd0;
      else if (unit < 6'd6)   sec = 3'd1;
      else if (unit < 6'd8)   sec = 3'd2;
      else if (unit < 6'd32)  sec = 3'd3;
      else                    sec = 3'd4;
    end
  end

  assign low    = !ce_n && !we_n;
  assign fire   = low && (cnt == CW'(FILT - 1));
  assign write  = fire && oe_n;
  assign boot   = (sec == 3'd0);
  assign held   = ovr_run && hv_override;
  assign refuse = supply_low || (boot && locked && !held);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt     <= '0;
      ovr_run <= 1'b1;
      locked  <= 1'b0;
      grant   <= 1'b0;
      reject  <= 1'b0;
      sector  <= 3'd0;
    end else begin
      if (!low)                    cnt <= '0;
      else if (cnt != CW'(FILT))   cnt <= cnt + 1'b1;
      ovr_run <= low ? held : 1'b1;
      if (lockout_cmd) locked <= 1'b1;
      grant  <= write && !refuse;
      reject <= write && refuse;
      if (write) sector <= sec;
    end
  end

  assign id_dout = (id_mode && !ce_n && !oe_n && addr == STAT_ADDR) ? {7'b0, locked} : 8'h00;

  p_single_outcome_r2: assert property (@(posedge clk) disable iff (!por_n)
    !(grant && reject));
  p_strobe_low_r3: assert property (@(posedge clk) disable iff (!por_n)
    (grant || reject) |-> $past(!ce_n && !we_n && oe_n));
  p_supply_r5: assert property (@(posedge clk) disable iff (!por_n)
    grant |-> !$past(supply_low));
  p_lock_set_r6: assert property (@(posedge clk) disable iff (!por_n)
    lockout_cmd |=> locked);
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!por_n)
    locked |=> locked);
  p_boot_guard_r7: assert property (@(posedge clk) disable iff (!por_n)
    (grant && sector == 3'd0) |-> (!$past(locked) || $past(hv_override)));
  p_pulse_r2: assert property (@(posedge clk) disable iff (!por_n)
    grant |=> !grant);
endmodule

// File: tb/flash_sector_guard_test.sv
module flash_sector_guard_test;
  localparam int FILT = 3;
  logic clk = 0, por_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1;
  logic [17:0] addr = '0;
  logic supply_low = 0, hv_override = 0, lockout_cmd = 0, id_mode = 0;
  logic grant, reject;
  logic [2:0] sector;
  logic [7:0] id_dout;
  int total = 0, bad = 0;
  int g_cnt = 0, r_cnt = 0;
  logic [2:0] last_sec = '0;
  bit lock_m = 0;

  flash_sector_guard #(.ADDR_W(18), .TOP_BOOT(1'b1), .FILT(FILT)) uut (
    .clk(clk), .por_n(por_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .supply_low(supply_low), .hv_override(hv_override),
    .lockout_cmd(lockout_cmd), .id_mode(id_mode), .grant(grant),
    .reject(reject), .sector(sector), .id_dout(id_dout));

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    #1;
    if (grant)  g_cnt++;
    if (reject) r_cnt++;
    if (grant || reject) last_sec = sector;
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_sec(logic [17:0] a);
    int u = int'(a[17:12]);
    if (u >= 60) return 3'd0;
    if (u >= 58) return 3'd2;
    if (u >= 56) return 3'd1;
    if (u >= 32) return 3'd3;
    return 3'd4;
  endfunction

  // 0 none, 1 grant, 2 reject
  function automatic int exp_out(logic [17:0] a, int n, bit oel, bit sl, bit ovr_all);
    if (n < FILT) return 0;
    if (oel) return 0;
    if (sl) return 2;
    if (exp_sec(a) == 3'd0 && lock_m && !ovr_all) return 2;
    return 1;
  endfunction

  task automatic strobe(string req, logic [17:0] a, int n, bit oel, bit sl,
                        bit ovr, int drop);
    int e;
    @(negedge clk);
    g_cnt = 0; r_cnt = 0;
    addr = a; oe_n = !oel; supply_low = sl;
    ce_n = 0; we_n = 0;
    for (int i = 0; i < n; i++) begin
      hv_override = ovr && (i != drop);
      if (i > 0) @(negedge clk);
      hv_override = ovr && (i != drop);
    end
    @(negedge clk);
    ce_n = 1; we_n = 1; hv_override = 0; oe_n = 1; supply_low = 0;
    repeat (2) @(negedge clk);
    #2;
    e = exp_out(a, n, oel, sl, ovr && (drop < 0 || drop >= FILT));
    check(req, g_cnt, e == 1 ? 1 : 0);
    check(req, r_cnt, e == 2 ? 1 : 0);
    if (e != 0) check({req, " sector R1"}, int'(last_sec), int'(exp_sec(a)));
  endtask

  task automatic set_lock();
    @(negedge clk);
    lockout_cmd = 1;
    @(negedge clk);
    lockout_cmd = 0;
    lock_m = 1;
  endtask

  task automatic id_read(string req, logic [17:0] a, int exp);
    @(negedge clk);
    id_mode = 1; addr = a; ce_n = 0; oe_n = 0; we_n = 1;
    #1;
    check(req, int'(id_dout), exp);
    @(negedge clk);
    id_mode = 0; ce_n = 1; oe_n = 1;
  endtask

  initial begin
    void'($urandom(32'd4177));
    repeat (3) @(negedge clk);
    check("R8 reset grant", int'(grant), 0);
    check("R8 reset reject", int'(reject), 0);
    por_n = 1;
    repeat (2) @(negedge clk);
    id_read("R9 unlocked status", 18'h3C002, 0);

    strobe("R1 main128", 18'h01234, 3, 0, 0, 0, -1);
    strobe("R1 main96", 18'h37FFF, 3, 0, 0, 0, -1);
    strobe("R1 paramA", 18'h38000, 3, 0, 0, 0, -1);
    strobe("R1 paramB", 18'h3BFFF, 3, 0, 0, 0, -1);
    strobe("R1 boot unlocked", 18'h3C000, 3, 0, 0, 0, -1);
    strobe("R2 long strobe", 18'h20000, 9, 0, 0, 0, -1);
    strobe("R3 glitch one", 18'h20000, 1, 0, 0, 0, -1);
    strobe("R3 glitch two", 18'h3C000, 2, 0, 0, 0, -1);
    strobe("R4 oe low", 18'h10000, 4, 1, 0, 0, -1);
    strobe("R5 supply low", 18'h10000, 3, 0, 1, 0, -1);

    set_lock();
    id_read("R9 locked status", 18'h3C002, 1);
    id_read("R9 wrong address", 18'h3C003, 0);
    strobe("R6 boot locked", 18'h3FFFF, 3, 0, 0, 0, -1);
    strobe("R6 paramB locked", 18'h3A000, 3, 0, 0, 0, -1);
    strobe("R7 override held", 18'h3C100, 3, 0, 0, 1, -1);
    strobe("R7 override dropped", 18'h3C100, 3, 0, 0, 1, 1);
    strobe("R7 override released", 18'h3C100, 3, 0, 0, 0, -1);

    for (int k = 0; k < 80; k++) begin
      logic [17:0] a = 18'($urandom);
      int n = 1 + int'($urandom % 5);
      bit oel = ($urandom % 8) == 0;
      bit sl = ($urandom % 8) == 0;
      bit ovr = ($urandom % 4) == 0;
      int drop = (($urandom % 3) == 0) ? int'($urandom % 3) : -1;
      if (($urandom % 4) == 0) a[17:14] = 4'hF;
      if (k == 40) begin
        @(negedge clk); por_n = 0; @(negedge clk); por_n = 1; lock_m = 0;
        id_read("R8 lock cleared by por", 18'h3C002, 0);
      end
      if (k > 50 && !lock_m) set_lock();
      strobe("R2 random", a, n, oel, sl, ovr, drop);
    end
    id_read("R8 lock kept", 18'h3C002, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule